// File: doc/BRIEF.md
# Descriptor Chain Command Sequencer

This block sits in a storage-card host controller, between software, system memory and the engine that drives the card bus. Software writes one start word. That word holds a word-aligned base address for a chain of descriptors and a start bit. From then on the sequencer needs no software help. It reads each 16-byte descriptor over a memory read port, one word at a time. It decodes the descriptor and hands the resulting command or data job to the card-bus engine. It waits for that engine to report completion, then moves to the next descriptor 16 bytes further on. The chain ends at a descriptor flagged as last, at a descriptor that software does not own, at an engine error, at a timeout, or when software writes a stop.

A descriptor holds four words, fetched in this order: control flags, command argument, data buffer address, response buffer address. Each descriptor carries a timeout exponent N. The engine must finish the job within 2^N ticks of the millisecond strobe. When the engine reports an error, the sequencer marks the descriptor in memory by setting its error bit, then halts. Four sticky status flags record why the chain stopped. Any write to the start word clears them.

The memory read request, the memory write request and the job request are valid/ready channels. Once raised, a valid stays high with its payload unchanged until ready is seen at a clock edge. The only exception is a write to the start word, which withdraws every request at once. Read responses and job completions are single-cycle strobes and are always accepted.

Top module: `desc_chain_seq`

## Requirements
- R1: A write to the start word with bit 1 set makes `busy` high after that clock edge. Fetching then begins at the address formed by the written word with bits 1:0 forced to zero. Bit 0 of the written word is ignored. The four words of a descriptor are read at offsets +0, +4, +8 and +12, in that order.
- R2: A write to the start word with bit 1 clear leaves the block idle after that edge, with no further read, write or job request. Any write to the start word clears all four status flags.
- R3: When flags bit 31 (owner) of a fetched descriptor is 0, the sequencer issues no job and reads no more words. It sets `st_desc_err` and stops.
- R4: Each job presents the decoded fields of its descriptor:
  - command index from flags bits 29:24
  - long response from bit 21
  - skip CRC check from bit 20
  - write direction from bit 19
  - data present from bit 18
  - skip command phase from bit 17
  - no response from bit 16
  - busy wait from bit 10
  - block mode from bit 9
  - argument, data address and response address from words 1, 2 and 3
- R5: `job_len` is the flags field in bits 8:0. The one exception is block mode (bit 9) with a field of 0, where `job_len` is 512.
- R6: While `rd_req_valid` or `job_valid` is high and its ready is low, the request and its payload stay unchanged on the next cycle, unless the start word is written.
- R7: After a successful job whose descriptor has bit 11 (end of chain) set, the block sets `st_eoc`, drops `busy` and issues no further request.
- R8: After a successful job whose descriptor is not the last, the next descriptor is fetched at the previous descriptor address plus 16.
- R9: When a job ends with `job_err`, the block writes the flags word with bit 30 set back to the descriptor's own address. It then sets `st_job_err` and stops.
- R10: Only `ms_tick` pulses that arrive while a job is outstanding are counted. On the 2^N-th such pulse, where N is flags bits 15:12, the block sets `st_timeout` and stops. A completion in that same cycle takes priority.
- R11: `busy` is low out of reset and whenever the block is idle. No request valid is ever high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Start-word write strobe |
| cfg_wdata | input | 32 | Start word: bits 31:2 base address, bit 1 start |
| busy | output | 1 | Chain in progress |
| st_eoc | output | 1 | Chain ended at a last descriptor |
| st_desc_err | output | 1 | Chain ended at a descriptor not owned |
| st_timeout | output | 1 | Chain ended by job timeout |
| st_job_err | output | 1 | Chain ended by engine error |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Memory read byte address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| job_valid | output | 1 | Job request valid |
| job_ready | input | 1 | Job accepted by engine |
| job_cmd_idx | output | 6 | Command index |
| job_arg | output | 32 | Command argument |
| job_data_addr | output | 32 | Data buffer address |
| job_resp_addr | output | 32 | Response buffer address |
| job_long_resp | output | 1 | Long response expected |
| job_no_crc | output | 1 | Skip response CRC check |
| job_write | output | 1 | Data direction is write |
| job_data_en | output | 1 | Data phase present |
| job_skip_cmd | output | 1 | Continue previous data phase without a command |
| job_no_resp | output | 1 | No response expected |
| job_busy_wait | output | 1 | Wait for busy after response |
| job_block_mode | output | 1 | Length counts blocks |
| job_len | output | 10 | Decoded length |
| job_done | input | 1 | Job completion strobe |
| job_err | input | 1 | Completion carries an error |
| ms_tick | input | 1 | Millisecond strobe |

## Verification
The assertions assume well-behaved neighbours:
- A read response arrives only after a read request has been accepted, with at most one read outstanding.
- `job_done` arrives only for a job that has been accepted.
- The start word is never written while a read response is still due.

The bench memory replies exactly one cycle after each accepted read. Its engine model strobes completion a scripted number of cycles after accepting a job, or never when the job is meant to time out. Aborts are issued only while a job is outstanding.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int FL_OWNER   = 31;
  localparam int FL_ERR     = 30;
  localparam int FL_CMD_LO  = 24;
  localparam int CMD_W      = 6;
  localparam int CTL_LO     = 9;
  localparam int CTL_W      = 13;
  localparam int LEN_FLD_W  = 9;
  localparam int JOB_LEN_W  = LEN_FLD_W + 1;
  localparam int EXP_W      = 4;
  localparam int START_BIT  = 1;

  // control field positions relative to CTL_LO
  localparam int C_LONG   = 21 - CTL_LO;
  localparam int C_NOCRC  = 20 - CTL_LO;
  localparam int C_WRITE  = 19 - CTL_LO;
  localparam int C_DATA   = 18 - CTL_LO;
  localparam int C_SKIP   = 17 - CTL_LO;
  localparam int C_NORESP = 16 - CTL_LO;
  localparam int C_TMO_LO = 12 - CTL_LO;
  localparam int C_EOC    = 11 - CTL_LO;
  localparam int C_BUSYW  = 10 - CTL_LO;
  localparam int C_BLOCK  = 9 - CTL_LO;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_ISSUE, S_RUN, S_WBACK
  } seq_state_e;

  typedef struct packed {
    logic [CMD_W-1:0]     cmd_idx;
    logic                 long_resp;
    logic                 no_crc;
    logic                 write;
    logic                 data_en;
    logic                 skip_cmd;
    logic                 no_resp;
    logic                 busy_wait;
    logic                 block_mode;
    logic                 eoc;
    logic [EXP_W-1:0]     tmo_exp;
    logic [JOB_LEN_W-1:0] len;
  } job_ctl_t;
endpackage

// File: rtl/dcs_decode.sv
module dcs_decode
  import dcs_pkg::*;
(
  input  logic [CMD_W-1:0]     cmd_fld,
  input  logic [CTL_W-1:0]     ctl_fld,
  input  logic [LEN_FLD_W-1:0] len_fld,
  output job_ctl_t             ctl
);
  localparam logic [JOB_LEN_W-1:0] FULL_BLOCKS = JOB_LEN_W'(1) << LEN_FLD_W;

  always_comb begin
    ctl.cmd_idx    = cmd_fld;
    ctl.long_resp  = ctl_fld[C_LONG];
    ctl.no_crc     = ctl_fld[C_NOCRC];
    ctl.write      = ctl_fld[C_WRITE];
    ctl.data_en    = ctl_fld[C_DATA];
    ctl.skip_cmd   = ctl_fld[C_SKIP];
    ctl.no_resp    = ctl_fld[C_NORESP];
    ctl.busy_wait  = ctl_fld[C_BUSYW];
    ctl.block_mode = ctl_fld[C_BLOCK];
    ctl.eoc        = ctl_fld[C_EOC];
    ctl.tmo_exp    = ctl_fld[C_TMO_LO +: EXP_W];
    // a zero block count stands for the largest count
    if (ctl_fld[C_BLOCK] && (len_fld == '0))
      ctl.len = FULL_BLOCKS;
    else
      ctl.len = {1'b0, len_fld};
  end
endmodule

// File: rtl/dcs_desc_regs.sv
module dcs_desc_regs #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DW-1:0]             din,
  output logic [WORDS-1:0][DW-1:0]  words
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (load && (idx == IDX_W'(g)))
        words[g] <= din;
    end
  end
endmodule

// File: rtl/dcs_timer.sv
module dcs_timer #(
  parameter int EXP_W = 4,
  localparam int CNT_W = 1 << EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limit;

  assign limit   = (CNT_W+1)'(1) << exp_sel;
  assign expired = run && tick && (({1'b0, cnt} + (CNT_W+1)'(1)) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [DW-1:0]        cfg_wdata,
  output logic                 busy,
  output logic                 st_eoc,
  output logic                 st_desc_err,
  output logic                 st_timeout,
  output logic                 st_job_err,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [DW-1:0]        rd_req_addr,
  input  logic                 rd_rsp_valid,
  input  logic [DW-1:0]        rd_rsp_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [DW-1:0]        wr_addr,
  output logic [DW-1:0]        wr_data,
  output logic                 job_valid,
  input  logic                 job_ready,
  output logic [CMD_W-1:0]     job_cmd_idx,
  output logic [DW-1:0]        job_arg,
  output logic [DW-1:0]        job_data_addr,
  output logic [DW-1:0]        job_resp_addr,
  output logic                 job_long_resp,
  output logic                 job_no_crc,
  output logic                 job_write,
  output logic                 job_data_en,
  output logic                 job_skip_cmd,
  output logic                 job_no_resp,
  output logic                 job_busy_wait,
  output logic                 job_block_mode,
  output logic [JOB_LEN_W-1:0] job_len,
  input  logic                 job_done,
  input  logic                 job_err,
  input  logic                 ms_tick
);
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int WB_SHIFT   = $clog2(DW / 8);
  localparam int DESC_BYTES = DESC_WORDS * (DW / 8);
  localparam logic [DW-1:0] ALIGN_MASK = ~DW'((1 << WB_SHIFT) - 1);

  seq_state_e                     state;
  logic [DW-1:0]                  base_q;
  logic [IDX_W-1:0]               widx;
  logic [DESC_WORDS-1:0][DW-1:0]  words;
  job_ctl_t                       ctl;
  logic                           tmo_hit;
  logic                           word_load;
  logic                           run_q;

  assign word_load = (state == S_WAIT) && rd_rsp_valid;
  assign run_q     = (state == S_RUN);

  dcs_desc_regs #(.WORDS(DESC_WORDS), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (word_load),
    .idx   (widx),
    .din   (rd_rsp_data),
    .words (words)
  );

  dcs_decode u_dec (
    .cmd_fld (words[0][FL_CMD_LO +: CMD_W]),
    .ctl_fld (words[0][CTL_LO +: CTL_W]),
    .len_fld (words[0][LEN_FLD_W-1:0]),
    .ctl     (ctl)
  );

  dcs_timer #(.EXP_W(EXP_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .tick    (ms_tick),
    .exp_sel (ctl.tmo_exp),
    .expired (tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      base_q      <= '0;
      widx        <= '0;
      st_eoc      <= 1'b0;
      st_desc_err <= 1'b0;
      st_timeout  <= 1'b0;
      st_job_err  <= 1'b0;
    end else if (cfg_we) begin
      st_eoc      <= 1'b0;
      st_desc_err <= 1'b0;
      st_timeout  <= 1'b0;
      st_job_err  <= 1'b0;
      widx        <= '0;
      base_q      <= cfg_wdata & ALIGN_MASK;
      state       <= cfg_wdata[START_BIT] ? S_REQ : S_IDLE;
    end else begin
      case (state)
        S_REQ:   if (rd_req_ready) state <= S_WAIT;
        S_WAIT: begin
          if (rd_rsp_valid) begin
            if ((widx == '0) && !rd_rsp_data[FL_OWNER]) begin
              st_desc_err <= 1'b1;
              state       <= S_IDLE;
            end else if (widx == IDX_W'(DESC_WORDS - 1)) begin
              state <= S_ISSUE;
            end else begin
              widx  <= widx + IDX_W'(1);
              state <= S_REQ;
            end
          end
        end
        S_ISSUE: if (job_ready) state <= S_RUN;
        S_RUN: begin
          if (job_done) begin
            if (job_err) begin
              state <= S_WBACK;
            end else if (ctl.eoc) begin
              st_eoc <= 1'b1;
              state  <= S_IDLE;
            end else begin
              base_q <= base_q + DW'(DESC_BYTES);
              widx   <= '0;
              state  <= S_REQ;
            end
          end else if (tmo_hit) begin
            st_timeout <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_WBACK: begin
          if (wr_ready) begin
            st_job_err <= 1'b1;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state != S_IDLE);
  assign rd_req_valid   = (state == S_REQ);
  assign rd_req_addr    = base_q + (DW'(widx) << WB_SHIFT);
  assign wr_valid       = (state == S_WBACK);
  assign wr_addr        = base_q;
  assign wr_data        = words[0] | (DW'(1) << FL_ERR);
  assign job_valid      = (state == S_ISSUE);
  assign job_cmd_idx    = ctl.cmd_idx;
  assign job_arg        = words[1];
  assign job_data_addr  = words[2];
  assign job_resp_addr  = words[3];
  assign job_long_resp  = ctl.long_resp;
  assign job_no_crc     = ctl.no_crc;
  assign job_write      = ctl.write;
  assign job_data_en    = ctl.data_en;
  assign job_skip_cmd   = ctl.skip_cmd;
  assign job_no_resp    = ctl.no_resp;
  assign job_busy_wait  = ctl.busy_wait;
  assign job_block_mode = ctl.block_mode;
  assign job_len        = ctl.len;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic        busy,
  input logic        st_eoc,
  input logic        st_desc_err,
  input logic        st_timeout,
  input logic        st_job_err,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_addr,
  input logic        wr_valid,
  input logic        job_valid,
  input logic        job_ready,
  input logic [5:0]  job_cmd_idx,
  input logic [31:0] job_arg,
  input logic [9:0]  job_len
);
  a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1]) |=> busy);

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[1]) |=> (!busy && !rd_req_valid && !job_valid && !wr_valid));

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !cfg_we) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r6_job_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && !job_ready && !cfg_we) |=>
      (job_valid && $stable(job_arg) && $stable(job_cmd_idx) && $stable(job_len)));

  a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_eoc) |-> !busy);

  a_r11_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || job_valid || wr_valid) |-> busy);

  a_r11_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_eoc, st_desc_err, st_timeout, st_job_err}));
endmodule

bind desc_chain_seq dcs_checker u_chk (.*);

// File: tb/desc_chain_seq_test.sv
module desc_chain_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        busy, st_eoc, st_desc_err, st_timeout, st_job_err;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic        job_valid, job_ready;
  logic [5:0]  job_cmd_idx;
  logic [31:0] job_arg, job_data_addr, job_resp_addr;
  logic        job_long_resp, job_no_crc, job_write, job_data_en;
  logic        job_skip_cmd, job_no_resp, job_busy_wait, job_block_mode;
  logic [9:0]  job_len;
  logic        job_done, job_err, ms_tick;

  always #4 clk = ~clk;

  desc_chain_seq uut (.*);

  typedef struct {
    logic [31:0] f, a, d, r;
    int lat;
    bit err;
    bit hang;
  } jexp_t;

  int checks = 0, fails = 0, cyc = 0, jobs_acc = 0, last_job_cyc = 0;
  logic [31:0] mem [0:255];
  logic [31:0] exp_rd[$];
  jexp_t       exp_job[$];
  logic [31:0] exp_wb_a[$], exp_wb_d[$];
  bit          rd_bp = 0, job_bp = 0, pend = 0, eng_busy = 0, eng_hang = 0, eng_errq = 0;
  logic [31:0] pend_addr;
  int          eng_cnt = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory, engine, monitor: decides inputs for the coming edge at each falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R11 watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    ms_tick = (cyc % 4 == 0);
    // read port
    rd_rsp_valid = 1'b0;
    if (pend) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[pend_addr[9:2]];
      pend = 0;
    end
    rd_req_ready = rd_bp ? (cyc % 2 == 0) : 1'b1;
    if (rd_req_valid && rd_req_ready) begin
      if (exp_rd.size() == 0) chk(0, "R8 unexpected read", rd_req_addr, 0);
      else begin
        logic [31:0] e;
        e = exp_rd.pop_front();
        chk(rd_req_addr == e, "R8 read address", rd_req_addr, e);
      end
      pend = 1;
      pend_addr = rd_req_addr;
    end
    // engine
    job_done = 1'b0;
    job_err  = 1'b0;
    if (eng_busy && !eng_hang) begin
      eng_cnt--;
      if (eng_cnt <= 0) begin
        job_done = 1'b1;
        job_err  = eng_errq;
        eng_busy = 0;
      end
    end
    job_ready = job_bp ? (cyc % 3 == 0) : 1'b1;
    if (job_valid && job_ready) begin
      jobs_acc++;
      last_job_cyc = cyc;
      if (exp_job.size() == 0) chk(0, "R3 unexpected job", job_arg, 0);
      else begin
        jexp_t j;
        logic [9:0] el;
        j = exp_job.pop_front();
        el = (j.f[9] && j.f[8:0] == 0) ? 10'd512 : {1'b0, j.f[8:0]};
        chk(job_cmd_idx == j.f[29:24], "R4 command index", job_cmd_idx, j.f[29:24]);
        chk({job_long_resp, job_no_crc, job_write, job_data_en, job_skip_cmd,
             job_no_resp, job_busy_wait, job_block_mode} ==
            {j.f[21], j.f[20], j.f[19], j.f[18], j.f[17], j.f[16], j.f[10], j.f[9]},
            "R4 control bits",
            {job_long_resp, job_no_crc, job_write, job_data_en, job_skip_cmd,
             job_no_resp, job_busy_wait, job_block_mode},
            {j.f[21], j.f[20], j.f[19], j.f[18], j.f[17], j.f[16], j.f[10], j.f[9]});
        chk({job_arg, job_data_addr} == {j.a, j.d}, "R4 argument and data address",
            {job_arg, job_data_addr}, {j.a, j.d});
        chk(job_resp_addr == j.r, "R4 response address", job_resp_addr, j.r);
        chk(job_len == el, "R5 length", job_len, el);
        eng_busy = 1; eng_cnt = j.lat; eng_errq = j.err; eng_hang = j.hang;
      end
    end
    // write port
    wr_ready = 1'b1;
    if (wr_valid) begin
      if (exp_wb_a.size() == 0) chk(0, "R9 unexpected write", wr_addr, 0);
      else begin
        logic [31:0] ea, ed;
        ea = exp_wb_a.pop_front();
        ed = exp_wb_d.pop_front();
        chk(wr_addr == ea, "R9 write address", wr_addr, ea);
        chk(wr_data == ed, "R9 write data", wr_data, ed);
      end
      mem[wr_addr[9:2]] = wr_data;
    end
    if ((rd_req_valid || job_valid || wr_valid) && !busy)
      chk(0, "R11 request while idle", {rd_req_valid, job_valid, wr_valid}, 0);
  end

  function automatic logic [31:0] mkf(bit own, logic [5:0] cmd, bit lng, bit nocrc,
                                      bit wr, bit dat, bit skip, bit noresp,
                                      logic [3:0] tmo, bit eoc, bit r1b, bit blk,
                                      logic [8:0] len);
    return {own, 1'b0, cmd, 2'b00, lng, nocrc, wr, dat, skip, noresp, tmo, eoc, r1b, blk, len};
  endfunction

  task automatic put_desc(logic [31:0] ad, logic [31:0] f, int lat, bit err, bit hang, bit fetched);
    jexp_t j;
    j.f = f; j.a = ad ^ 32'hA5A5_0000; j.d = ad + 32'h1000_0000; j.r = ad + 32'h2000_0000;
    j.lat = lat; j.err = err; j.hang = hang;
    mem[ad[9:2]] = f; mem[ad[9:2] + 1] = j.a; mem[ad[9:2] + 2] = j.d; mem[ad[9:2] + 3] = j.r;
    if (fetched) begin
      exp_rd.push_back(ad);
      if (f[31]) begin
        for (int k = 1; k < 4; k++) exp_rd.push_back(ad + 32'(4 * k));
        exp_job.push_back(j);
      end
    end
  endtask

  task automatic write_start(logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic end_check(string req);
    chk(exp_rd.size() == 0, req, exp_rd.size(), 0);
    chk(exp_job.size() == 0, req, exp_job.size(), 0);
    chk(exp_wb_a.size() == 0, req, exp_wb_a.size(), 0);
  endtask

  task automatic chk_status(logic [3:0] e, string req);
    chk({st_eoc, st_desc_err, st_timeout, st_job_err} == e, req,
        {st_eoc, st_desc_err, st_timeout, st_job_err}, e);
  endtask

  initial begin
    logic [31:0] f;
    int t0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    chk_status(4'b0000, "R11 reset status");
    chk({rd_req_valid, job_valid, wr_valid} == 3'b000, "R11 reset requests",
        {rd_req_valid, job_valid, wr_valid}, 0);

    // R1 R4 R5 R7 R8: three descriptors, bit 0 of start word set
    put_desc(32'h100, mkf(1, 6'd17, 0, 0, 0, 1, 0, 0, 4'd12, 0, 0, 1, 9'd0), 3, 0, 0, 1);
    put_desc(32'h110, mkf(1, 6'd25, 1, 1, 1, 1, 1, 0, 4'd12, 0, 0, 0, 9'd5), 5, 0, 0, 1);
    put_desc(32'h120, mkf(1, 6'd63, 0, 0, 0, 0, 0, 1, 4'd12, 1, 1, 1, 9'd3), 2, 0, 0, 1);
    write_start(32'h0000_0103);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    wait_idle();
    chk_status(4'b1000, "R7 end of chain status");
    end_check("R8 chain fully walked");

    // R6: back-pressure on reads and jobs
    rd_bp = 1; job_bp = 1;
    put_desc(32'h200, mkf(1, 6'd2, 0, 0, 0, 1, 0, 0, 4'd12, 0, 0, 1, 9'd511), 4, 0, 0, 1);
    put_desc(32'h210, mkf(1, 6'd3, 0, 0, 1, 1, 0, 0, 4'd12, 1, 0, 0, 9'd0), 1, 0, 0, 1);
    write_start(32'h0000_0202);
    wait_idle();
    chk_status(4'b1000, "R6 chain under back-pressure");
    end_check("R6 all handshakes");
    rd_bp = 0; job_bp = 0;

    // R3: second descriptor not owned
    put_desc(32'h300, mkf(1, 6'd7, 0, 0, 0, 0, 0, 0, 4'd12, 0, 0, 0, 9'd0), 2, 0, 0, 1);
    put_desc(32'h310, mkf(0, 6'd8, 0, 0, 0, 0, 0, 0, 4'd12, 1, 0, 0, 9'd0), 2, 0, 0, 1);
    write_start(32'h0000_0302);
    wait_idle();
    chk_status(4'b0100, "R3 descriptor error status");
    end_check("R3 fetch stopped after flags");

    // R9: engine error marks the descriptor
    f = mkf(1, 6'd9, 0, 0, 0, 1, 0, 0, 4'd12, 0, 0, 1, 9'd2);
    put_desc(32'h340, f, 3, 1, 0, 1);
    put_desc(32'h350, mkf(1, 6'd10, 0, 0, 0, 0, 0, 0, 4'd12, 1, 0, 0, 9'd0), 2, 0, 0, 0);
    exp_wb_a.push_back(32'h340); exp_wb_d.push_back(f | 32'h4000_0000);
    write_start(32'h0000_0342);
    wait_idle();
    chk_status(4'b0001, "R9 job error status");
    chk(mem[8'hD0] == (f | 32'h4000_0000), "R9 error bit in memory", mem[8'hD0], f | 32'h4000_0000);
    end_check("R9 chain halted");

    // R10: exponent 2 with no completion
    put_desc(32'h380, mkf(1, 6'd11, 0, 0, 0, 0, 0, 0, 4'd2, 1, 0, 0, 9'd0), 1, 0, 1, 1);
    write_start(32'h0000_0382);
    wait_idle();
    t0 = cyc - last_job_cyc;
    chk_status(4'b0010, "R10 timeout status");
    chk(t0 >= 12 && t0 <= 20, "R10 timeout after four ticks", t0, 16);
    end_check("R10 timeout chain");

    // R10: exponent 0 expires at the first tick
    put_desc(32'h390, mkf(1, 6'd12, 0, 0, 0, 0, 0, 0, 4'd0, 1, 0, 0, 9'd0), 40, 0, 0, 1);
    write_start(32'h0000_0392);
    wait_idle();
    t0 = cyc - last_job_cyc;
    chk_status(4'b0010, "R10 single tick timeout");
    chk(t0 <= 6, "R10 single tick timing", t0, 4);
    repeat (45) @(negedge clk);
    end_check("R10 single tick chain");

    // R10: exponent 3 is not reached by a 20-cycle job
    put_desc(32'h3A0, mkf(1, 6'd13, 0, 0, 0, 0, 0, 0, 4'd3, 1, 0, 0, 9'd0), 20, 0, 0, 1);
    write_start(32'h0000_03A2);
    wait_idle();
    chk_status(4'b1000, "R10 no early timeout");
    end_check("R10 completed chain");

    // R2: write with bit 1 clear clears status
    write_start(32'h0000_0000);
    chk_status(4'b0000, "R2 status cleared by write");
    chk(busy == 1'b0, "R2 idle after stop write", busy, 0);

    // R2: abort while a job is outstanding
    t0 = jobs_acc;
    put_desc(32'h3C0, mkf(1, 6'd14, 0, 0, 0, 0, 0, 0, 4'd15, 0, 0, 0, 9'd0), 1, 0, 1, 1);
    put_desc(32'h3D0, mkf(1, 6'd15, 0, 0, 0, 0, 0, 0, 4'd15, 1, 0, 0, 9'd0), 1, 0, 0, 0);
    write_start(32'h0000_03C2);
    for (int i = 0; i < 200 && jobs_acc == t0; i++) @(negedge clk);
    write_start(32'h0000_3C00);
    chk(busy == 1'b0, "R2 busy dropped on abort", busy, 0);
    chk_status(4'b0000, "R2 no status on abort");
    repeat (8) @(negedge clk);
    chk({rd_req_valid, job_valid, wr_valid} == 3'b000, "R2 no requests after abort",
        {rd_req_valid, job_valid, wr_valid}, 0);
    end_check("R2 aborted chain");

    // R1: restart after abort
    put_desc(32'h3E0, mkf(1, 6'd1, 0, 0, 0, 0, 0, 1, 4'd12, 1, 0, 0, 9'd0), 2, 0, 0, 1);
    write_start(32'h0000_03E2);
    chk(busy == 1'b1, "R1 restart busy", busy, 1);
    wait_idle();
    chk_status(4'b1000, "R1 restart completes");
    end_check("R1 restart chain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule